// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block turns digital supply-status flags from external comparators into the reset and warning signals of a small system. A primary supply-good flag, a secondary monitor-good flag and a power-valid flag come in as ideal digital levels. The block drives three outputs: an active-low system reset, an active-low secondary-fail warning, and a one-cycle abort pulse that tells the serial interface to drop any command in progress.

Reset is held for a qualified time after the primary supply becomes good, and the same hold time follows a watchdog expiry. The watchdog is restarted only by the start-condition pulse that the serial interface raises when it detects a bus start. All delays are counted in milliseconds from one shared prescaler. The prescaler's period in clock cycles is a parameter, so a simulation can use short values. The secondary-fail output has no timer and follows its monitor one clock later.

Top module: `sup_reset_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `rst_n_o` and `aux_fail_n_o` are low and `abort_o` is low.
- R2: While `pwr_valid` is high and `main_ok` is low, `rst_n_o` is low from the next clock on.
- R3: The prescaler raises a tick every `CYCLES_PER_MS` clocks, counting from the release of `rst`. Once the supply fault clears, `rst_n_o` rises on the clock that takes the `HOLD_MS`-th tick with the supply good, and not before.
- R4: Any fault cycle during the hold period restarts the hold count from zero.
- R5: When `wdg_en` is high, reset is released and `WDG_MS` ticks pass with no `start_pulse`, the watchdog expires. `rst_n_o` then goes low and is held for `HOLD_MS` ticks before it is released again.
- R6: Each `start_pulse` clears the watchdog count, so starts spaced closer than the timeout keep `rst_n_o` high.
- R7: The watchdog count is held at zero while `wdg_en` is low and while reset is held. With the watchdog disabled, `rst_n_o` never falls for lack of starts.
- R8: `aux_fail_n_o` equals `pwr_valid && aux_ok` sampled on the previous clock, with no extra delay on release.
- R9: `abort_o` is a one-cycle pulse on the first clock after a supply fault begins. It does not repeat while the fault persists and is never raised by a watchdog expiry.
- R10: While `pwr_valid` is low, `rst_n_o` and `aux_fail_n_o` are both low from the next clock on, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_valid | input | 1 | Supply above the minimum level at which the outputs are valid |
| main_ok | input | 1 | Primary supply above its trip level |
| aux_ok | input | 1 | Secondary monitor above its trip level |
| start_pulse | input | 1 | One-cycle pulse for each detected serial start condition |
| wdg_en | input | 1 | Watchdog enable |
| rst_n_o | output | 1 | Active-low system reset |
| aux_fail_n_o | output | 1 | Active-low secondary-fail warning |
| abort_o | output | 1 | One-cycle abort request to the serial interface |

## Verification
The bench drops the primary supply for a single cycle in the middle of a hold period. A design that kept counting instead of restarting would release reset about one hold period too early. It lets the watchdog starve with no supply fault. A design that tied abort to the reset output would pulse abort on the expiry, and one whose reset hold ran on the wrong counter would release at the wrong tick. It also runs long stretches with the watchdog disabled or fed by starts, which catches a counter that is not cleared, and it lowers power-valid while both supply flags stay good. A per-clock reference model exposes any latency error on the secondary-fail path, such as a release that waits for a tick.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Snapshot of the comparator flags seen by the supervisor.
  typedef struct packed {
    logic pwr_valid;
    logic main_ok;
    logic aux_ok;
  } supply_t;

  // A reset-worthy condition on the primary side.
  function automatic logic main_fault(input supply_t s);
    return !s.pwr_valid || !s.main_ok;
  endfunction

  // Secondary warning condition.
  function automatic logic aux_fault(input supply_t s);
    return !s.pwr_valid || !s.aux_ok;
  endfunction
endpackage

// File: rtl/sup_tick_gen.sv
module sup_tick_gen #(
  parameter int unsigned CYCLES_PER_MS = 200_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int unsigned HOLD_MS = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  output logic holding
);
  localparam int unsigned HW = $clog2(HOLD_MS + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_MS - 1);

  logic [HW-1:0] cnt_q;
  logic          hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (restart) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q && tick) begin
      if (cnt_q == LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign holding = hold_q;
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned WDG_MS = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  output logic expire
);
  localparam int unsigned WW = $clog2(WDG_MS + 1);
  localparam logic [WW-1:0] LAST = WW'(WDG_MS - 1);

  logic [WW-1:0] cnt_q;

  assign expire = !clear && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (tick)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int unsigned CYCLES_PER_MS = 200_000,
  parameter int unsigned HOLD_MS       = 150,
  parameter int unsigned WDG_MS        = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_valid,
  input  logic main_ok,
  input  logic aux_ok,
  input  logic start_pulse,
  input  logic wdg_en,
  output logic rst_n_o,
  output logic aux_fail_n_o,
  output logic abort_o
);
  import sup_pkg::*;

  supply_t sup;
  logic    tick, holding, wd_expire, fault;
  logic    fault_q, aux_n_q, abort_q;

  assign sup   = '{pwr_valid: pwr_valid, main_ok: main_ok, aux_ok: aux_ok};
  assign fault = main_fault(sup);

  sup_tick_gen #(.CYCLES_PER_MS(CYCLES_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  sup_hold_timer #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk(clk), .rst(rst), .tick(tick),
    .restart(fault || wd_expire), .holding(holding)
  );

  sup_watchdog #(.WDG_MS(WDG_MS)) u_wdg (
    .clk(clk), .rst(rst), .tick(tick),
    .clear(holding || !wdg_en || start_pulse), .expire(wd_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b1;
      aux_n_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      fault_q <= fault;
      aux_n_q <= !aux_fault(sup);
      abort_q <= fault && !fault_q;
    end
  end

  assign rst_n_o      = !holding;
  assign aux_fail_n_o = aux_n_q;
  assign abort_o      = abort_q;
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk (
  input logic clk,
  input logic rst,
  input logic pwr_valid,
  input logic main_ok,
  input logic aux_ok,
  input logic rst_n_o,
  input logic aux_fail_n_o,
  input logic abort_o
);
  a_r2_fault_resets: assert property (@(posedge clk) disable iff (rst)
    (pwr_valid && !main_ok) |=> !rst_n_o);

  a_r10_pv_low_both: assert property (@(posedge clk) disable iff (rst)
    !pwr_valid |=> (!rst_n_o && !aux_fail_n_o));

  a_r8_aux_release: assert property (@(posedge clk) disable iff (rst)
    (pwr_valid && aux_ok) |=> aux_fail_n_o);

  a_r8_aux_assert: assert property (@(posedge clk) disable iff (rst)
    !aux_ok |=> !aux_fail_n_o);

  a_r9_abort_single: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o);

  a_r9_abort_with_reset: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> !rst_n_o);

  a_r3_release_needs_supply: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> $past(pwr_valid && main_ok));
endmodule

bind sup_reset_ctrl sup_reset_chk u_chk (
  .clk(clk), .rst(rst), .pwr_valid(pwr_valid), .main_ok(main_ok),
  .aux_ok(aux_ok), .rst_n_o(rst_n_o), .aux_fail_n_o(aux_fail_n_o),
  .abort_o(abort_o)
);

// File: tb/sim_sup_reset_ctrl.sv
`timescale 1ns/1ps
module sim_sup_reset_ctrl;
  localparam int CPM  = 4;
  localparam int HOLD = 5;
  localparam int WDG  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_valid = 1'b1, main_ok = 1'b1, aux_ok = 1'b1;
  logic start_pulse = 1'b0, wdg_en = 1'b0;
  logic rst_n_o, aux_fail_n_o, abort_o;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  sup_reset_ctrl #(.CYCLES_PER_MS(CPM), .HOLD_MS(HOLD), .WDG_MS(WDG)) u0 (
    .clk(clk), .rst(rst), .pwr_valid(pwr_valid), .main_ok(main_ok),
    .aux_ok(aux_ok), .start_pulse(start_pulse), .wdg_en(wdg_en),
    .rst_n_o(rst_n_o), .aux_fail_n_o(aux_fail_n_o), .abort_o(abort_o)
  );

  // Behavioural reference: millisecond clock, reset hold, watchdog, edges.
  int  ms_phase, hold_ms, wd_ms;
  bit  in_reset, was_fault;
  bit  exp_rstn, exp_auxn, exp_abort;
  int  abort_seen, rstn_low_seen;

  always @(posedge clk) begin
    bit tk, flt, exp_fire;
    if (rst) begin
      ms_phase = 0; hold_ms = 0; wd_ms = 0;
      in_reset = 1; was_fault = 1;
      exp_rstn = 0; exp_auxn = 0; exp_abort = 0;
    end else begin
      tk  = (ms_phase == CPM - 1);
      flt = !pwr_valid || !main_ok;
      exp_fire = wdg_en && !in_reset && !start_pulse && tk && (wd_ms == WDG - 1);
      if (in_reset || !wdg_en || start_pulse) wd_ms = 0;
      else if (tk) wd_ms = (wd_ms == WDG - 1) ? 0 : wd_ms + 1;
      if (flt || exp_fire) begin
        in_reset = 1; hold_ms = 0;
      end else if (in_reset && tk) begin
        if (hold_ms == HOLD - 1) begin in_reset = 0; hold_ms = 0; end
        else hold_ms++;
      end
      exp_abort = flt && !was_fault;
      was_fault = flt;
      exp_auxn  = pwr_valid && aux_ok;
      exp_rstn  = !in_reset;
      ms_phase  = tk ? 0 : ms_phase + 1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(phase, rst_n_o, exp_rstn, "rst_n_o");
      check("R8", aux_fail_n_o, exp_auxn, "aux_fail_n_o");
      check("R9", abort_o, exp_abort, "abort_o");
      if (abort_o) abort_seen++;
      if (!rst_n_o) rstn_low_seen++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 200 && rst_n_o !== 1'b1; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        cyc(3);
        @(negedge clk) rst = 1'b0;
        // R1 reset state, sampled on the first negedge after reset release
        check("R1", rst_n_o, 1'b0, "rst_n_o after reset");
        check("R1", aux_fail_n_o, 1'b0, "aux_fail_n_o after reset");
        check("R1", abort_o, 1'b0, "abort_o after reset");

        phase = "R3";
        cyc(10);
        check("R3", rst_n_o, 1'b0, "rst_n_o before hold done");
        cyc(20);
        check("R3", rst_n_o, 1'b1, "rst_n_o after hold");

        phase = "R2"; abort_seen = 0;
        main_ok = 1'b0; cyc(2);
        check("R2", rst_n_o, 1'b0, "rst_n_o on supply low");
        cyc(10);
        check("R9", abort_seen == 1, 1'b1, "single abort pulse");

        phase = "R4";
        main_ok = 1'b1; cyc(12);
        main_ok = 1'b0; cyc(1); main_ok = 1'b1;
        cyc(12);
        check("R4", rst_n_o, 1'b0, "hold restarted after glitch");
        wait_release();
        check("R4", rst_n_o, 1'b1, "release after full hold");

        phase = "R8";
        aux_ok = 1'b0; cyc(2);
        check("R8", aux_fail_n_o, 1'b0, "aux fail asserted");
        check("R8", rst_n_o, 1'b1, "reset untouched by aux");
        aux_ok = 1'b1; cyc(1);
        check("R8", aux_fail_n_o, 1'b1, "aux release no delay");

        phase = "R5"; abort_seen = 0; rstn_low_seen = 0;
        wdg_en = 1'b1; cyc(60);
        check("R5", rstn_low_seen > 0, 1'b1, "watchdog reset seen");
        check("R9", abort_seen == 0, 1'b1, "no abort on watchdog");

        phase = "R6";
        wdg_en = 1'b0; wait_release();
        wdg_en = 1'b1; rstn_low_seen = 0;
        for (int k = 0; k < 12; k++) begin
          start_pulse = 1'b1; cyc(1); start_pulse = 1'b0; cyc(9);
        end
        check("R6", rstn_low_seen == 0, 1'b1, "fed watchdog keeps reset high");

        phase = "R7";
        wdg_en = 1'b0; rstn_low_seen = 0; cyc(100);
        check("R7", rstn_low_seen == 0, 1'b1, "disabled watchdog silent");

        phase = "R10";
        pwr_valid = 1'b0; cyc(2);
        check("R10", rst_n_o, 1'b0, "rst_n_o with power invalid");
        check("R10", aux_fail_n_o, 1'b0, "aux_fail_n_o with power invalid");
        pwr_valid = 1'b1; wait_release();
        check("R10", rst_n_o, 1'b1, "recovery after power valid");
        cyc(2);
      end
      begin
        cyc(20000);
        errors++;
        $display("FAIL watchdog expired R1 actual=hung expected=done");
      end
    join_any
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule